// File: doc/BRIEF.md
# Multi-Width Add/Subtract Flag and Compare Unit

This block is a purely combinational arithmetic slice for a 32-bit integer datapath. It adds, subtracts or reverse-subtracts two operands through one shared carry chain. From the same chain it derives the carry/borrow flag and three signed-overflow flags: one for the full width, one for the low 16-bit half and one for the low byte. The narrow overflow flags let byte and halfword arithmetic find out about overflow without extra instructions.

The same adder also serves two set-less-than operations, one signed and one unsigned. Each writes 0 or 1 to the result and leaves the condition flags alone. The unit takes the current low flag bits and returns them updated, at their flag-register positions, so the caller can write them straight back. An overflow-trap request is raised when a full-width overflow occurs and the caller's trap-enable bit is set.

Top module: `addflag_unit`

## Requirements
- R1: Op code 0 (add) returns `a + b` modulo 2^32, and flag bit 0 (carry) becomes the carry out of bit 31.
- R2: Op code 1 (subtract) returns `a - b`, and flag bit 0 becomes 1 exactly when `a < b` unsigned (a borrow).
- R3: Op code 2 (reverse subtract) returns `b - a`, and flag bit 0 becomes 1 exactly when `b < a` unsigned.
- R4: For op codes 0 to 2, flag bit 1 is 1 exactly when the 32-bit signed result overflows.
- R5: For op codes 0 to 2, flag bit 3 is 1 exactly when the same operation on the low 16 bits overflows as a signed 16-bit value.
- R6: For op codes 0 to 2, flag bit 4 is 1 exactly when the same operation on the low 8 bits overflows as a signed 8-bit value.
- R7: Op code 3 (signed set-less-than) returns 1 when `a < b` as signed values and 0 otherwise, and the flags leave the block equal to the flags that entered it.
- R8: Op code 4 (unsigned set-less-than) returns 1 when `a < b` unsigned and 0 otherwise, and the flags are passed through unchanged.
- R9: The overflow-trap request is 1 exactly when the op code is 0 to 2, the 32-bit overflow of R4 occurs and the trap-enable input is 1.
- R10: Flag bit 2 (division error) passes through unchanged for every op code.
- R11: Op codes 5 to 7 return 0, pass all flags through unchanged and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_op_a | input | 32 | First operand |
| i_op_b | input | 32 | Second operand |
| i_op | input | 3 | Operation code (see R1 to R11) |
| i_flags | input | 5 | Current flag bits 4..0 |
| i_ovf_trap_en | input | 1 | Overflow-trap enable bit from the flags register |
| o_result | output | 32 | Arithmetic result, or 0/1 from a compare |
| o_flags | output | 5 | Updated flag bits 4..0 |
| o_ovf_trap | output | 1 | Overflow-trap request |

## Verification
Every output is a function of the present inputs only, so each result, each flag and the trap request is due in the same cycle as the stimulus that causes it, with no register in the path. The bench applies each vector one time unit after a rising clock edge and samples all outputs four time units later, well before the next edge. Each vector is therefore judged on its own inputs alone. The signed and unsigned flag terms are recomputed in the bench from plain 32-, 16- and 8-bit arithmetic, not from carry-chain taps.

// File: rtl/addflag_pkg.sv
package addflag_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_RSB  = 3'd2,
      OP_SLT  = 3'd3,
      OP_SLTU = 3'd4
   } alu_op_e;

   // positions inside the low flag field
   localparam int FLG_CF  = 0;
   localparam int FLG_OF  = 1;
   localparam int FLG_DE  = 2;
   localparam int FLG_OWF = 3;
   localparam int FLG_OBF = 4;
   localparam int FLG_W   = 5;

   // carry chain implementation variants
   localparam int CHAIN_RIPPLE = 0;
   localparam int CHAIN_INFER  = 1;
endpackage

// File: rtl/addflag_opsel.sv
module addflag_opsel
   import addflag_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] i_a,
   input  logic [DATA_W-1:0] i_b,
   input  logic [OP_W-1:0]   i_op,
   output logic [DATA_W-1:0] o_x,
   output logic [DATA_W-1:0] o_y,
   output logic              o_cin,
   output logic              o_arith,
   output logic              o_borrow,
   output logic              o_slt_s,
   output logic              o_slt_u
);
   always_comb begin
      o_x      = i_a;
      o_y      = i_b;
      o_cin    = 1'b0;
      o_arith  = 1'b0;
      o_borrow = 1'b0;
      o_slt_s  = 1'b0;
      o_slt_u  = 1'b0;
      case (i_op)
         OP_ADD: begin
            o_arith = 1'b1;
         end
         OP_SUB: begin
            o_y      = ~i_b;
            o_cin    = 1'b1;
            o_arith  = 1'b1;
            o_borrow = 1'b1;
         end
         OP_RSB: begin
            o_x      = i_b;
            o_y      = ~i_a;
            o_cin    = 1'b1;
            o_arith  = 1'b1;
            o_borrow = 1'b1;
         end
         OP_SLT: begin
            o_y     = ~i_b;
            o_cin   = 1'b1;
            o_slt_s = 1'b1;
         end
         OP_SLTU: begin
            o_y     = ~i_b;
            o_cin   = 1'b1;
            o_slt_u = 1'b1;
         end
         default: begin
            o_x = i_a;
         end
      endcase
   end
endmodule

// File: rtl/addflag_chain.sv
module addflag_chain #(
   parameter int DATA_W      = 32,
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int CHAIN_STYLE = 0
) (
   input  logic [DATA_W-1:0] i_x,
   input  logic [DATA_W-1:0] i_y,
   input  logic              i_cin,
   output logic [DATA_W-1:0] o_sum,
   output logic              o_cout,
   output logic              o_c_top,
   output logic              o_c_word_in,
   output logic              o_c_word_out,
   output logic              o_c_byte_in,
   output logic              o_c_byte_out
);
   localparam int TOP = DATA_W - 1;

   if (CHAIN_STYLE == 0) begin : g_ripple
      logic [DATA_W:0] c;
      assign c[0] = i_cin;
      for (genvar k = 0; k < DATA_W; k++) begin : g_bit
         logic p;
         assign p        = i_x[k] ^ i_y[k];
         assign o_sum[k] = p ^ c[k];
         assign c[k+1]   = (i_x[k] & i_y[k]) | (p & c[k]);
      end
      assign o_cout       = c[DATA_W];
      assign o_c_top      = c[TOP];
      assign o_c_word_in  = c[WORD_W-1];
      assign o_c_word_out = c[WORD_W];
      assign o_c_byte_in  = c[BYTE_W-1];
      assign o_c_byte_out = c[BYTE_W];
   end else begin : g_infer
      logic [DATA_W:0] full;
      assign full   = {1'b0, i_x} + {1'b0, i_y} + {{DATA_W{1'b0}}, i_cin};
      assign o_sum  = full[DATA_W-1:0];
      assign o_cout = full[DATA_W];
      // carry into bit k recovered from sum and operand bits
      assign o_c_top      = full[TOP] ^ i_x[TOP] ^ i_y[TOP];
      assign o_c_word_in  = full[WORD_W-1] ^ i_x[WORD_W-1] ^ i_y[WORD_W-1];
      assign o_c_word_out = full[WORD_W] ^ i_x[WORD_W] ^ i_y[WORD_W];
      assign o_c_byte_in  = full[BYTE_W-1] ^ i_x[BYTE_W-1] ^ i_y[BYTE_W-1];
      assign o_c_byte_out = full[BYTE_W] ^ i_x[BYTE_W] ^ i_y[BYTE_W];
   end
endmodule

// File: rtl/addflag_flags.sv
module addflag_flags (
   input  logic i_cout,
   input  logic i_c_top,
   input  logic i_c_word_in,
   input  logic i_c_word_out,
   input  logic i_c_byte_in,
   input  logic i_c_byte_out,
   input  logic i_sum_msb,
   input  logic i_borrow,
   output logic o_cf,
   output logic o_of,
   output logic o_owf,
   output logic o_obf,
   output logic o_lt_s,
   output logic o_lt_u
);
   always_comb begin
      o_of   = i_c_top ^ i_cout;
      o_owf  = i_c_word_in ^ i_c_word_out;
      o_obf  = i_c_byte_in ^ i_c_byte_out;
      o_cf   = i_borrow ? ~i_cout : i_cout;
      o_lt_s = i_sum_msb ^ o_of;
      o_lt_u = ~i_cout;
   end
endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
   import addflag_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int CHAIN_STYLE = CHAIN_RIPPLE
) (
   input  logic [DATA_W-1:0] i_op_a,
   input  logic [DATA_W-1:0] i_op_b,
   input  logic [OP_W-1:0]   i_op,
   input  logic [FLG_W-1:0]  i_flags,
   input  logic              i_ovf_trap_en,
   output logic [DATA_W-1:0] o_result,
   output logic [FLG_W-1:0]  o_flags,
   output logic              o_ovf_trap
);
   localparam int PAD_W = DATA_W - 1;

   if (!(BYTE_W >= 2 && WORD_W > BYTE_W && DATA_W > WORD_W)) begin : g_bad_widths
      $error("addflag_unit: need 2 <= BYTE_W < WORD_W < DATA_W");
   end
   if (CHAIN_STYLE != CHAIN_RIPPLE && CHAIN_STYLE != CHAIN_INFER) begin : g_bad_style
      $error("addflag_unit: unknown CHAIN_STYLE");
   end

   logic [DATA_W-1:0] x, y, sum;
   logic cin, arith, borrow, slt_s, slt_u;
   logic cout, c_top, c_w_in, c_w_out, c_b_in, c_b_out;
   logic cf, of, owf, obf, lt_s, lt_u;

   addflag_opsel #(.DATA_W(DATA_W)) i_opsel (
      .i_a(i_op_a), .i_b(i_op_b), .i_op(i_op),
      .o_x(x), .o_y(y), .o_cin(cin), .o_arith(arith),
      .o_borrow(borrow), .o_slt_s(slt_s), .o_slt_u(slt_u)
   );

   addflag_chain #(
      .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .CHAIN_STYLE(CHAIN_STYLE)
   ) i_chain (
      .i_x(x), .i_y(y), .i_cin(cin), .o_sum(sum), .o_cout(cout),
      .o_c_top(c_top), .o_c_word_in(c_w_in), .o_c_word_out(c_w_out),
      .o_c_byte_in(c_b_in), .o_c_byte_out(c_b_out)
   );

   addflag_flags i_flags_calc (
      .i_cout(cout), .i_c_top(c_top),
      .i_c_word_in(c_w_in), .i_c_word_out(c_w_out),
      .i_c_byte_in(c_b_in), .i_c_byte_out(c_b_out),
      .i_sum_msb(sum[DATA_W-1]), .i_borrow(borrow),
      .o_cf(cf), .o_of(of), .o_owf(owf), .o_obf(obf),
      .o_lt_s(lt_s), .o_lt_u(lt_u)
   );

   always_comb begin
      o_result = '0;
      if (arith)      o_result = sum;
      else if (slt_s) o_result = {{PAD_W{1'b0}}, lt_s};
      else if (slt_u) o_result = {{PAD_W{1'b0}}, lt_u};
   end

   always_comb begin
      o_flags = i_flags;
      if (arith) begin
         o_flags[FLG_CF]  = cf;
         o_flags[FLG_OF]  = of;
         o_flags[FLG_OWF] = owf;
         o_flags[FLG_OBF] = obf;
      end
   end

   assign o_ovf_trap = arith & of & i_ovf_trap_en;
endmodule

// File: rtl/addflag_unit_chk.sv
module addflag_unit_chk
   import addflag_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic [DATA_W-1:0] a,
   input logic [DATA_W-1:0] b,
   input logic [OP_W-1:0]   op,
   input logic [FLG_W-1:0]  fin,
   input logic              trap_en,
   input logic [DATA_W-1:0] res,
   input logic [FLG_W-1:0]  fout,
   input logic              trap
);
   always_comb begin
      AST_ADD_RESULT: assert (op != OP_ADD || res == a + b) else $error("add result"); // R1
      AST_SUB_RESULT: assert (op != OP_SUB || res == a - b) else $error("sub result"); // R2
      AST_SUB_BORROW: assert (op != OP_SUB || fout[FLG_CF] == (a < b)) else $error("sub borrow"); // R2
      AST_RSB_RESULT: assert (op != OP_RSB || res == b - a) else $error("rsb result"); // R3
      AST_TRAP_GATED: assert (!trap || (trap_en && fout[FLG_OF] && op <= 3'd2)) else $error("trap"); // R9
      AST_DE_KEPT: assert (fout[FLG_DE] == fin[FLG_DE]) else $error("de bit"); // R10
      AST_SLT_BOOLEAN: assert ((op != OP_SLT && op != OP_SLTU) || (res <= 1 && fout == fin)) else $error("slt"); // R7
      AST_SPARE_CODE: assert (op <= 3'd4 || (res == '0 && fout == fin && !trap)) else $error("spare op"); // R11
   end
endmodule

bind addflag_unit addflag_unit_chk #(.DATA_W(DATA_W)) i_chk (
   .a(i_op_a), .b(i_op_b), .op(i_op), .fin(i_flags), .trap_en(i_ovf_trap_en),
   .res(o_result), .fout(o_flags), .trap(o_ovf_trap)
);

// File: tb/test_addflag_unit.sv
module test_addflag_unit;
   logic        clk = 1'b0;
   logic [31:0] a = '0, b = '0;
   logic [2:0]  op = '0;
   logic [4:0]  fin = '0;
   logic        en = 1'b0;
   logic [31:0] res;
   logic [4:0]  fout;
   logic        trap;
   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   addflag_unit i_addflag_unit (
      .i_op_a(a), .i_op_b(b), .i_op(op), .i_flags(fin), .i_ovf_trap_en(en),
      .o_result(res), .o_flags(fout), .o_ovf_trap(trap)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h", req, what, op, a, b, act, exp);
      end
   endtask

   function automatic logic sov(input logic sx, input logic sy, input logic sr, input logic sub);
      return sub ? (sx != sy && sr != sx) : (sx == sy && sr != sx);
   endfunction

   task automatic run(input logic [31:0] va, input logic [31:0] vb, input logic [2:0] vop,
                      input logic [4:0] vf, input logic ven);
      logic [31:0] x, y, er, r;
      logic [15:0] r16;
      logic [7:0]  r8;
      logic [32:0] wide;
      logic [4:0]  ef;
      logic sub, arith, eof, etrap;
      string rq;
      @(posedge clk);
      #1;
      a = va; b = vb; op = vop; fin = vf; en = ven;
      #4;
      arith = (vop <= 3'd2);
      x = (vop == 3'd2) ? vb : va;
      y = (vop == 3'd2) ? va : vb;
      sub = (vop != 3'd0);
      r = sub ? x - y : x + y;
      r16 = sub ? x[15:0] - y[15:0] : x[15:0] + y[15:0];
      r8 = sub ? x[7:0] - y[7:0] : x[7:0] + y[7:0];
      wide = {1'b0, x} + {1'b0, y};
      eof = sov(x[31], y[31], r[31], sub);
      ef = vf;
      er = '0;
      etrap = 1'b0;
      case (vop)
         3'd0: rq = "R1";
         3'd1: rq = "R2";
         3'd2: rq = "R3";
         3'd3: rq = "R7";
         3'd4: rq = "R8";
         default: rq = "R11";
      endcase
      if (arith) begin
         er = r;
         ef[0] = sub ? (x < y) : wide[32];
         ef[1] = eof;
         ef[3] = sov(x[15], y[15], r16[15], sub);
         ef[4] = sov(x[7], y[7], r8[7], sub);
         etrap = eof & ven;
      end else if (vop == 3'd3) begin
         er = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
      end else if (vop == 3'd4) begin
         er = (va < vb) ? 32'd1 : 32'd0;
      end
      chk(rq, "result", res, er);
      chk(arith ? rq : rq, "carry", {31'd0, fout[0]}, {31'd0, ef[0]});
      chk(arith ? "R4" : rq, "ovf32", {31'd0, fout[1]}, {31'd0, ef[1]});
      chk(arith ? "R5" : rq, "ovf16", {31'd0, fout[3]}, {31'd0, ef[3]});
      chk(arith ? "R6" : rq, "ovf8", {31'd0, fout[4]}, {31'd0, ef[4]});
      chk("R10", "divflag", {31'd0, fout[2]}, {31'd0, ef[2]});
      chk(arith ? "R9" : rq, "trap", {31'd0, trap}, {31'd0, etrap});
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      // idle state: zero operands with the add code give all zeros (R1)
      #6;
      chk("R1", "idle result", res, 32'd0);
      chk("R1", "idle flags", {27'd0, fout}, 32'd0);
      chk("R9", "idle trap", {31'd0, trap}, 32'd0);
      // directed corners
      run(32'h7FFF_FFFF, 32'h1, 3'd0, 5'b0, 1'b1);     // R4 R9 signed overflow, trap
      run(32'h7FFF_FFFF, 32'h1, 3'd0, 5'b0, 1'b0);     // R9 trap disabled
      run(32'hFFFF_FFFF, 32'h1, 3'd0, 5'b0, 1'b1);     // R1 carry without overflow
      run(32'h0, 32'h1, 3'd1, 5'b0, 1'b0);             // R2 borrow
      run(32'h8000_0000, 32'h1, 3'd1, 5'b00100, 1'b1); // R4 R10 sub overflow
      run(32'h1, 32'h0, 3'd2, 5'b0, 1'b0);             // R3 reverse borrow
      run(32'h0000_007F, 32'h1, 3'd0, 5'b0, 1'b0);     // R6 byte overflow only
      run(32'h0000_7FFF, 32'h1, 3'd0, 5'b0, 1'b0);     // R5 halfword overflow only
      run(32'h0000_0080, 32'h1, 3'd1, 5'b0, 1'b0);     // R6 byte sub overflow
      run(32'hFFFF_FFFF, 32'h1, 3'd3, 5'b11111, 1'b1); // R7 signed less
      run(32'hFFFF_FFFF, 32'h1, 3'd4, 5'b11111, 1'b1); // R8 unsigned not less
      run(32'h1234, 32'h1234, 3'd3, 5'b01010, 1'b1);   // R7 equal
      run(32'h8000_0000, 32'h7FFF_FFFF, 3'd1, 5'b0, 1'b1); // R4 R9
      run(32'h5, 32'h9, 3'd6, 5'b10101, 1'b1);         // R11 spare code
      run(32'h7FFF_FFFF, 32'h8000_0000, 3'd7, 5'b01011, 1'b1); // R11
      // constrained random
      for (int i = 0; i < 600; i++) begin
         logic [31:0] ra, rb;
         ra = $urandom();
         rb = $urandom();
         if (i % 4 == 0) rb = ra ^ 32'(1 << $urandom_range(0, 31));
         if (i % 7 == 0) ra = {ra[31], 23'h7FFFFF, ra[7:0]};
         run(ra, rb, 3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule